// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides, cycle by cycle, whether a shared DRAM data bus carries read bursts or write bursts, and it sequences the dead time needed when the direction flips. It watches the occupancy counts of an external read queue and an external write queue. It also sees one pulse for each read burst and one for each write burst that is actually issued. From these it drives a two-bit bus mode and a pair of grants that tell the downstream command picker which queue may issue next.

Reads are served by default. The bus turns to writes in two cases: when the write queue reaches a high watermark, or when no reads wait and writes do. Once in write mode, the bus stays there until reads are waiting and one of two things holds. Either the write queue has emptied, or it has fallen to a low watermark after a minimum number of writes have gone out. Each change of direction passes through a turnaround state that lasts a fixed number of cycles, one length for each direction, and no grant is given during it. The block keeps a separate count of the bursts issued in the current read run and in the current write run.

Top module: `bus_turn_arb`

## Requirements
- R1: After reset, mode_o is 0 (read mode), both grants are 0 and both run counts are 0. Mode encoding: 0 read, 1 read-to-write turnaround, 2 write, 3 write-to-read turnaround.
- R2: In read mode, rd_grant_o is 1 exactly when rd_cnt_i is non-zero and wr_cnt_i is below HI_WM.
- R3: In read mode, wr_cnt_i >= HI_WM withdraws the read grant, and mode 1 follows at the next edge even while reads are pending.
- R4: In read mode, rd_cnt_i == 0 with wr_cnt_i != 0 moves the bus to mode 1 at the next edge, even below HI_WM.
- R5: Mode 1 lasts exactly T_RTW cycles with both grants low, then mode 2 follows.
- R6: In write mode, wr_grant_o is 1 while wr_cnt_i is non-zero and the leave condition of R7 is false. With no reads pending, the bus stays in write mode even when the write queue is empty.
- R7: Write mode is left (to mode 3) only when rd_cnt_i != 0 and either wr_cnt_i == 0, or both wr_cnt_i <= LO_WM and wr_run_o >= MIN_WR hold.
- R8: Mode 3 lasts exactly T_WTR cycles with both grants low, then mode 0 follows.
- R9: rd_run_o counts rd_issue_i pulses taken in mode 0 and clears on entry to mode 0. wr_run_o counts wr_issue_i pulses taken in mode 2 and clears on entry to mode 2.
- R10: An issue pulse that arrives outside its own mode leaves the run count unchanged.
- R11: The two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_cnt_i | input | CNT_W | Read queue occupancy |
| wr_cnt_i | input | CNT_W | Write queue occupancy |
| rd_issue_i | input | 1 | Pulse: a read burst was issued this cycle |
| wr_issue_i | input | 1 | Pulse: a write burst was issued this cycle |
| mode_o | output | 2 | Bus mode (0 read, 1 read-to-write, 2 write, 3 write-to-read) |
| rd_grant_o | output | 1 | The read queue may issue |
| wr_grant_o | output | 1 | The write queue may issue |
| rd_run_o | output | RUN_W | Reads issued in the current read run |
| wr_run_o | output | RUN_W | Writes issued in the current write run |

## Verification
Two pairs of functions can coincide. In read mode, the high-watermark turnaround can land in the same cycle as a read grant would be given. The bench raises wr_cnt_i to HI_WM while reads are pending and expects the grant to drop in that same cycle, with mode 1 on the next. In write mode, the empty-queue exit can meet the minimum-write rule. The bench empties the write queue after a single write with reads pending, and expects the exit to win over the unmet minimum.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;
  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_R2W = 2'd1,
    BUS_WR  = 2'd2,
    BUS_W2R = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/bt_delay.sv
module bt_delay #(
  parameter int DLY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bt_run_cnt.sv
module bt_run_cnt #(
  parameter int RUN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [RUN_W-1:0] cnt_o
);
  logic [RUN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && !(&cnt_q))     cnt_q <= cnt_q + 1'b1; // saturate
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bt_mode_fsm.sv
module bt_mode_fsm
  import bus_turn_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int RUN_W  = 8,
  parameter int DLY_W  = 2,
  parameter int HI_WM  = 12,
  parameter int LO_WM  = 4,
  parameter int MIN_WR = 3,
  parameter int T_RTW  = 2,
  parameter int T_WTR  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic [RUN_W-1:0] wr_run_i,
  input  logic             dly_zero_i,
  output logic             dly_load_o,
  output logic [DLY_W-1:0] dly_val_o,
  output bus_mode_e        mode_o,
  output logic             enter_rd_o,
  output logic             enter_wr_o,
  output logic             rd_grant_o,
  output logic             wr_grant_o
);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI_WM);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO_WM);
  localparam logic [RUN_W-1:0] MIN_C = RUN_W'(MIN_WR);
  localparam logic [DLY_W-1:0] RTW_C = DLY_W'(T_RTW - 1);
  localparam logic [DLY_W-1:0] WTR_C = DLY_W'(T_WTR - 1);

  bus_mode_e state_q, state_d;
  logic rd_pend, wr_pend, to_wr, to_rd;

  assign rd_pend = (rd_cnt_i != '0);
  assign wr_pend = (wr_cnt_i != '0);
  // turn to writes: watermark hit, or nothing else to do
  assign to_wr   = (wr_cnt_i >= HI_C) || (!rd_pend && wr_pend);
  // back to reads: only with reads waiting; empty queue overrides the minimum
  assign to_rd   = rd_pend && (!wr_pend || ((wr_cnt_i <= LO_C) && (wr_run_i >= MIN_C)));

  always_comb begin
    state_d    = state_q;
    dly_load_o = 1'b0;
    dly_val_o  = '0;
    unique case (state_q)
      BUS_RD: if (to_wr) begin
        state_d    = BUS_R2W;
        dly_load_o = 1'b1;
        dly_val_o  = RTW_C;
      end
      BUS_R2W: if (dly_zero_i) state_d = BUS_WR;
      BUS_WR: if (to_rd) begin
        state_d    = BUS_W2R;
        dly_load_o = 1'b1;
        dly_val_o  = WTR_C;
      end
      BUS_W2R: if (dly_zero_i) state_d = BUS_RD;
      default: state_d = BUS_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BUS_RD;
    else         state_q <= state_d;
  end

  assign mode_o     = state_q;
  assign enter_wr_o = (state_q == BUS_R2W) && dly_zero_i;
  assign enter_rd_o = (state_q == BUS_W2R) && dly_zero_i;
  assign rd_grant_o = (state_q == BUS_RD) && rd_pend && !to_wr;
  assign wr_grant_o = (state_q == BUS_WR) && wr_pend && !to_rd;
endmodule

// File: rtl/bus_turn_arb.sv
module bus_turn_arb
  import bus_turn_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int RUN_W  = 8,
  parameter int HI_WM  = 12,
  parameter int LO_WM  = 4,
  parameter int MIN_WR = 3,
  parameter int T_RTW  = 2,
  parameter int T_WTR  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rd_cnt_i,
  input  logic [CNT_W-1:0] wr_cnt_i,
  input  logic             rd_issue_i,
  input  logic             wr_issue_i,
  output logic [1:0]       mode_o,
  output logic             rd_grant_o,
  output logic             wr_grant_o,
  output logic [RUN_W-1:0] rd_run_o,
  output logic [RUN_W-1:0] wr_run_o
);
  localparam int T_MAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
  localparam int DLY_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  bus_mode_e        mode;
  logic             dly_load, dly_zero, enter_rd, enter_wr;
  logic [DLY_W-1:0] dly_val;
  logic [1:0]       run_clr, run_inc;
  logic [RUN_W-1:0] run_cnt [2];

  bt_mode_fsm #(
    .CNT_W(CNT_W), .RUN_W(RUN_W), .DLY_W(DLY_W), .HI_WM(HI_WM), .LO_WM(LO_WM),
    .MIN_WR(MIN_WR), .T_RTW(T_RTW), .T_WTR(T_WTR)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_cnt_i(rd_cnt_i), .wr_cnt_i(wr_cnt_i),
    .wr_run_i(run_cnt[1]), .dly_zero_i(dly_zero), .dly_load_o(dly_load),
    .dly_val_o(dly_val), .mode_o(mode), .enter_rd_o(enter_rd), .enter_wr_o(enter_wr),
    .rd_grant_o(rd_grant_o), .wr_grant_o(wr_grant_o)
  );

  bt_delay #(.DLY_W(DLY_W)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dly_load), .load_val_i(dly_val),
    .zero_o(dly_zero)
  );

  // index 0: read run, index 1: write run
  assign run_clr[0] = enter_rd;
  assign run_clr[1] = enter_wr;
  assign run_inc[0] = rd_issue_i && (mode == BUS_RD);
  assign run_inc[1] = wr_issue_i && (mode == BUS_WR);

  for (genvar g = 0; g < 2; g++) begin : g_run
    bt_run_cnt #(.RUN_W(RUN_W)) u_run (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(run_clr[g]), .inc_i(run_inc[g]),
      .cnt_o(run_cnt[g])
    );
  end

  assign mode_o   = mode;
  assign rd_run_o = run_cnt[0];
  assign wr_run_o = run_cnt[1];
endmodule

// File: rtl/bus_turn_arb_chk.sv
module bus_turn_arb_chk #(
  parameter int CNT_W  = 6,
  parameter int RUN_W  = 8,
  parameter int HI_WM  = 12,
  parameter int LO_WM  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] rd_cnt_i,
  input logic [CNT_W-1:0] wr_cnt_i,
  input logic [1:0]       mode_o,
  input logic             rd_grant_o,
  input logic             wr_grant_o,
  input logic [RUN_W-1:0] wr_run_o
);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_WM);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LO_WM);

  AST_GRANT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_grant_o && wr_grant_o)); // R11
  AST_TURN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[0]) |-> !(rd_grant_o || wr_grant_o)); // R5
  AST_HI_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && wr_cnt_i >= HI_C) |=> (mode_o == 2'd1)); // R3
  AST_R2W_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |=> (mode_o == 2'd1 || mode_o == 2'd2)); // R5
  AST_W2R_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3) |=> (mode_o == 2'd3 || mode_o == 2'd0)); // R8
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && wr_cnt_i > LO_C) |=> (mode_o == 2'd2)); // R7
  AST_WRUN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) == 2'd1) |-> (wr_run_o == '0)); // R9
  AST_WRUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 || mode_o == 2'd3) |=> $stable(wr_run_o)); // R10
endmodule

bind bus_turn_arb bus_turn_arb_chk #(
  .CNT_W(CNT_W), .RUN_W(RUN_W), .HI_WM(HI_WM), .LO_WM(LO_WM)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_cnt_i(rd_cnt_i), .wr_cnt_i(wr_cnt_i),
  .mode_o(mode_o), .rd_grant_o(rd_grant_o), .wr_grant_o(wr_grant_o),
  .wr_run_o(wr_run_o)
);

// File: tb/bus_turn_arb_tb_top.sv
`timescale 1ns/1ps
module bus_turn_arb_tb_top;
  localparam int CNT_W = 6;
  localparam int RUN_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] rd_cnt = '0, wr_cnt = '0;
  logic             rd_iss = 1'b0, wr_iss = 1'b0;
  logic [1:0]       mode;
  logic             rd_gnt, wr_gnt;
  logic [RUN_W-1:0] rd_run, wr_run;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] mode;
    bit rg, wg;
    int rrun, wrun;
    int req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk; // 125 MHz

  bus_turn_arb #(.CNT_W(CNT_W), .RUN_W(RUN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_cnt_i(rd_cnt), .wr_cnt_i(wr_cnt),
    .rd_issue_i(rd_iss), .wr_issue_i(wr_iss), .mode_o(mode),
    .rd_grant_o(rd_gnt), .wr_grant_o(wr_gnt), .rd_run_o(rd_run), .wr_run_o(wr_run)
  );

  // driver: apply one cycle of inputs, push what the outputs must show in it
  task automatic step(input int rd, input int wr, input bit ri, input bit wi,
                      input int m, input bit rg, input bit wg,
                      input int rr, input int wrn, input int req);
    exp_t e;
    @(negedge clk);
    rd_cnt = CNT_W'(rd); wr_cnt = CNT_W'(wr); rd_iss = ri; wr_iss = wi;
    e.mode = 2'(m); e.rg = rg; e.wg = wg; e.rrun = rr; e.wrun = wrn; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor: compare away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (mode !== e.mode || rd_gnt !== e.rg || wr_gnt !== e.wg ||
            (e.rrun >= 0 && int'(rd_run) != e.rrun) ||
            (e.wrun >= 0 && int'(wr_run) != e.wrun)) begin
          errors++;
          $display("FAIL R%0d: mode=%0d rg=%0b wg=%0b rrun=%0d wrun=%0d, expected mode=%0d rg=%0b wg=%0b rrun=%0d wrun=%0d",
                   e.req, mode, rd_gnt, wr_gnt, rd_run, wr_run,
                   e.mode, e.rg, e.wg, e.rrun, e.wrun);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R2 reads served below the watermark
    step(3, 2, 1, 0, 0, 1, 0, 0, 0, 2);
    step(3, 11, 1, 0, 0, 1, 0, 1, 0, 2);
    // R3 watermark hit with reads pending: grant withdrawn in this cycle
    step(3, 12, 0, 0, 0, 0, 0, 2, 0, 3);
    // R5 two turnaround cycles, R10 stray issues ignored
    step(3, 12, 1, 1, 1, 0, 0, 2, 0, 5);
    step(3, 12, 1, 1, 1, 0, 0, 2, 0, 10);
    // R6 write run, R9 starts from zero
    step(3, 12, 1, 1, 2, 0, 1, 2, 0, 9);
    // R7 at low watermark but minimum not met: stay
    step(3, 4, 0, 1, 2, 0, 1, 2, 1, 7);
    step(3, 4, 0, 1, 2, 0, 1, 2, 2, 7);
    // R7 minimum met and at low watermark: leave, no grant
    step(3, 4, 0, 0, 2, 0, 0, 2, 3, 7);
    // R8 three turnaround cycles, R10 read issues ignored
    step(3, 4, 1, 1, 3, 0, 0, 2, 3, 8);
    step(3, 4, 1, 0, 3, 0, 0, 2, 3, 10);
    step(3, 4, 0, 0, 3, 0, 0, 2, 3, 8);
    // R9 read run cleared on entry to read mode
    step(3, 4, 1, 0, 0, 1, 0, 0, 3, 9);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 2);
    // R4 no reads, one write pending below watermark
    step(0, 1, 0, 0, 0, 0, 0, 1, 3, 4);
    step(0, 1, 0, 0, 1, 0, 0, 1, 3, 5);
    step(0, 1, 0, 0, 1, 0, 0, 1, 3, 5);
    step(0, 1, 0, 1, 2, 0, 1, 1, 0, 6);
    // R6 empty write queue, no reads: stay in write mode
    step(0, 0, 0, 0, 2, 0, 0, 1, 1, 6);
    step(0, 0, 0, 0, 2, 0, 0, 1, 1, 6);
    // R7 reads arrive, queue empty: leave although minimum unmet
    step(2, 0, 0, 0, 2, 0, 0, 1, 1, 7);
    step(2, 0, 0, 0, 3, 0, 0, 1, 1, 8);
    step(2, 0, 0, 0, 3, 0, 0, 1, 1, 8);
    step(2, 0, 0, 0, 3, 0, 0, 1, 1, 8);
    step(2, 0, 0, 0, 0, 1, 0, 0, 1, 2);
    // R11 both queues busy below watermark: only reads granted
    step(2, 5, 0, 0, 0, 1, 0, 0, 1, 11);
    @(negedge clk);
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule